// File: doc/BRIEF.md
# GPIO Controller with Grouped Interrupts

This block is a register-mapped general-purpose I/O controller for a parameterised number of pins. Every pin owns a single 32-bit configuration word. In that word one 3-bit mode field selects both the direction (drive or sense) and, for sensing pins, the kind of event that raises an interrupt: high level, low level, rising edge, falling edge, either edge, or none. Writing the "no interrupt" mode masks a pin. Writing a trigger mode again unmasks it.

Pin inputs are synchronised with two flops. The block compares each synchronised level with its value from the previous cycle, so it can detect both levels and edges. A detected event is latched into a status bit for the pin. That bit sits in the status block of the interrupt group named in the pin's word. There are up to eight groups. Each group has its own block of write-one-to-clear status words and drives one interrupt line, which stays high while any of its status bits is set.

Several fields have no effect on the logic: pull, drive strength, hysteresis and lock. They are stored and returned on reads so that software can keep its settings in the block.

Top module: `gpio_grp_ctrl`

## Requirements
- R1: Pin n's word is at byte address 4*n. The bits kept in it are 0, 3:1, 6:5, 8:7, 9, 11:10, 15, 18:16, 21 and 23:22, so the write mask is 0x00E78FEF. Every other bit reads as 0. After reset every word is zero.
- R2: When the mode (bits 3:1) is 1, bit 0 reads back as the stored data bit. For any other mode, bit 0 reads back as the synchronised pin level. pin_do carries the stored data bit. pin_oe is 1 only when the mode is 1 and the function field (bits 6:5) is 0.
- R3: Mode 2 (high level) sets the pin's status bit in every cycle in which the synchronised level is 1. A clear written while the level is still 1 therefore has no lasting effect.
- R4: Mode 3 (low level) sets the status bit in every cycle in which the synchronised level is 0.
- R5: Mode 4 (rising) sets the bit only on a 0-to-1 change. A steady level sets nothing.
- R6: Mode 5 (falling) sets the bit only on a 1-to-0 change.
- R7: Mode 6 (either edge) sets the bit on any change of level.
- R8: Modes 0, 1 and 7 never set a status bit. Going from mode 7 back to a trigger mode re-enables event capture.
- R9: The status word for group g and pins 32k to 32k+31 is at byte address 0x800 + 0x40*g + 4*k, with pin p at bit p mod 32. A pin's event sets a bit only in the group named by bits 18:16. A group number of N_GROUPS or above sets nothing.
- R10: Writing a status word clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R11: irq[g] is 1 exactly when at least one status bit of group g is set.
- R12: Reads of unmapped addresses return 0, and writes to them change nothing. This covers configuration words past the last pin, groups at or above N_GROUPS, and status words past the last pin.
- R13: A status bit set by a pin change reads as 1 and shows on irq three clock edges after the pin changes: two synchroniser stages, then the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | N_PINS | Raw pin levels, asynchronous to clk |
| pin_oe | output | N_PINS | Output enable for each pin |
| pin_do | output | N_PINS | Output data for each pin |
| irq | output | N_GROUPS | One interrupt line per group |

## Verification
A table drives one pin through each of the eight mode codes. In each row the pin starts at a steady level, is armed, and then changes level. The status bit is checked after arming and again after the change. The steady-level check tells level triggers apart from edge triggers. The direction of the change tells rising from falling from either edge. The rows with modes 0, 1 and 7 show that those modes stay silent.

Directed sequences cover the rest:
- A pin in a high word is routed to a non-zero group, alongside a pin whose group number is out of range. This shows the address and bit mapping and the isolation between groups.
- A clear is attempted while a level is still present, and zero bits are written to a status word.
- Mask and unmask are exercised with a level already present.
- The stored bits are read back, and bit 0 is read as a live level in input modes.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;

  // Bits of a pin word that hold state; all others read as zero.
  localparam logic [31:0] CFG_KEEP = 32'h00E7_8FEF;

  typedef enum logic [2:0] {
    MD_NONE  = 3'd0,
    MD_DRIVE = 3'd1,
    MD_HIGH  = 3'd2,
    MD_LOW   = 3'd3,
    MD_RISE  = 3'd4,
    MD_FALL  = 3'd5,
    MD_BOTH  = 3'd6,
    MD_QUIET = 3'd7
  } pin_mode_e;

  // Event for one pin from its mode, current and previous level.
  function automatic logic trig_hit(logic [2:0] md, logic now, logic was);
    case (md)
      MD_HIGH: trig_hit = now;
      MD_LOW:  trig_hit = ~now;
      MD_RISE: trig_hit = now & ~was;
      MD_FALL: trig_hit = ~now & was;
      MD_BOTH: trig_hit = now ^ was;
      default: trig_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      synced <= '0;
    end else begin
      stage1 <= raw;
      synced <= stage1;
    end
  end
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
  import gpio_grp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WIDTH-1:0]      lvl,
  input  logic [WIDTH-1:0][2:0] mode,
  output logic [WIDTH-1:0]      evt
);
  logic [WIDTH-1:0] lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= '0;
    else        lvl_prev <= lvl;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign evt[i] = trig_hit(mode[i], lvl[i], lvl_prev[i]);

    // An edge event cannot repeat in the next cycle under the same mode.
    AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && (mode[i] == MD_RISE || mode[i] == MD_FALL))
        |=> !(evt[i] && $stable(mode[i]))); // R5
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int WIDTH  = 8,
  parameter int GRP_ID = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WIDTH-1:0]      evt,
  input  logic [WIDTH-1:0][2:0] grp,
  input  logic [WIDTH-1:0]      clr,
  output logic [WIDTH-1:0]      stat,
  output logic                  irq
);
  logic [WIDTH-1:0] set;

  for (genvar i = 0; i < WIDTH; i++) begin : g_match
    assign set[i] = evt[i] && (32'(grp[i]) == GRP_ID);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr) | set;
  end

  assign irq = |stat;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((stat & $past(clr & ~set)) == '0)); // R10
  AST_SET_ONLY_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(set)) == '0)); // R9
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set == '0 && clr == '0) |=> $stable(stat)); // R10
endmodule

// File: rtl/gpio_grp_ctrl.sv
module gpio_grp_ctrl
  import gpio_grp_pkg::*;
#(
  parameter int N_PINS   = 40,
  parameter int N_GROUPS = 4,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [N_PINS-1:0]   pin_in,
  output logic [N_PINS-1:0]   pin_oe,
  output logic [N_PINS-1:0]   pin_do,
  output logic [N_GROUPS-1:0] irq
);
  localparam int N_WORDS = (N_PINS + 31) / 32;
  localparam int IDX_W   = (N_PINS > 1) ? $clog2(N_PINS) : 1;
  localparam int GRP_W   = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;
  localparam int WRD_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int PAD_W   = N_WORDS * 32;

  // Address decode helpers
  function automatic logic is_cfg(logic [ADDR_W-1:0] a);
    return !a[11] && (32'(a[10:2]) < N_PINS);
  endfunction
  function automatic logic is_stat(logic [ADDR_W-1:0] a);
    return a[11] && (32'(a[10:6]) < N_GROUPS) && (32'(a[5:2]) < N_WORDS);
  endfunction

  logic [N_PINS-1:0][31:0]        cfg;
  logic [N_PINS-1:0][2:0]         mode_v;
  logic [N_PINS-1:0][2:0]         grp_v;
  logic [N_PINS-1:0]              lvl;
  logic [N_PINS-1:0]              evt;
  logic [N_GROUPS-1:0][N_PINS-1:0] stat_v;
  logic [N_GROUPS-1:0][PAD_W-1:0]  stat_pad;
  logic [N_GROUPS-1:0][PAD_W-1:0]  clr_pad;
  logic                           cfg_hit, stat_hit;
  logic [IDX_W-1:0]               pin_idx;
  logic [GRP_W-1:0]               grp_idx;
  logic [WRD_W-1:0]               wrd_idx;

  assign cfg_hit  = is_cfg(bus_addr);
  assign stat_hit = is_stat(bus_addr);
  assign pin_idx  = bus_addr[2 +: IDX_W];
  assign grp_idx  = bus_addr[6 +: GRP_W];
  assign wrd_idx  = bus_addr[2 +: WRD_W];

  // Configuration words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (bus_we && cfg_hit) begin
      cfg[pin_idx] <= bus_wdata & CFG_KEEP;
    end
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pinf
    assign mode_v[i] = cfg[i][3:1];
    assign grp_v[i]  = cfg[i][18:16];
    assign pin_do[i] = cfg[i][0];
    assign pin_oe[i] = (cfg[i][3:1] == MD_DRIVE) && (cfg[i][6:5] == 2'd0);
  end

  gpio_sync #(.WIDTH(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(lvl)
  );

  gpio_edge_detect #(.WIDTH(N_PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .mode(mode_v), .evt(evt)
  );

  // Write-one-to-clear masks, one per group
  always_comb begin
    clr_pad = '0;
    if (bus_we && stat_hit) begin
      for (int g = 0; g < N_GROUPS; g++) begin
        if (32'(grp_idx) == g) clr_pad[g][32*wrd_idx +: 32] = bus_wdata;
      end
    end
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    gpio_irq_bank #(.WIDTH(N_PINS), .GRP_ID(g)) u_bank (
      .clk(clk), .rst_n(rst_n), .evt(evt), .grp(grp_v),
      .clr(clr_pad[g][N_PINS-1:0]), .stat(stat_v[g]), .irq(irq[g])
    );
  end

  always_comb begin
    stat_pad = '0;
    for (int g = 0; g < N_GROUPS; g++) stat_pad[g][N_PINS-1:0] = stat_v[g];
  end

  // Read path
  always_comb begin
    bus_rdata = '0;
    if (cfg_hit) begin
      bus_rdata = cfg[pin_idx];
      if (cfg[pin_idx][3:1] != MD_DRIVE) bus_rdata[0] = lvl[pin_idx];
    end else if (stat_hit) begin
      bus_rdata = stat_pad[grp_idx][32*wrd_idx +: 32];
    end
  end

  AST_OE_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && cfg_hit && bus_wdata[3:1] != MD_DRIVE) |=> !pin_oe[$past(pin_idx)]); // R2
endmodule

// File: tb/gpio_grp_ctrl_test.sv
module gpio_grp_ctrl_test;
  localparam int NP = 40;
  localparam int NG = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_oe, pin_do;
  logic [NG-1:0] irq;

  int errors = 0;
  int checks = 0;
  logic [31:0] rd;

  gpio_grp_ctrl #(.N_PINS(NP), .N_GROUPS(NG), .ADDR_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_do(pin_do), .irq(irq)
  );

  always #4 clk = ~clk;

  // Rows: {mode, start level, next level, status after arming, status after change}
  localparam logic [6:0] VEC [15] = '{
    {3'd2, 1'b0, 1'b1, 1'b0, 1'b1}, {3'd2, 1'b1, 1'b0, 1'b1, 1'b1},
    {3'd3, 1'b1, 1'b0, 1'b0, 1'b1}, {3'd3, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd4, 1'b0, 1'b1, 1'b0, 1'b1}, {3'd4, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd5, 1'b1, 1'b0, 1'b0, 1'b1}, {3'd5, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd6, 1'b0, 1'b1, 1'b0, 1'b1}, {3'd6, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd7, 1'b0, 1'b1, 1'b0, 1'b0}, {3'd7, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd1, 1'b0, 1'b1, 1'b0, 1'b0}, {3'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd0, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rdreg(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    edges(3);
    @(negedge clk) rst_n = 1'b1;

    // Reset state: R1, R11, R12
    rdreg(12'h014, rd); check("R1 reset cfg", rd, 32'h0);
    rdreg(12'h800, rd); check("R12 reset status", rd, 32'h0);
    check("R11 reset irq", 32'(irq), 32'h0);

    // Mode table on pin 3, group 0: R3 R4 R5 R6 R7 R8 R13
    for (int v = 0; v < 15; v++) begin
      logic [2:0] md;
      md = VEC[v][6:4];
      wr(12'h00C, 32'hE);
      @(negedge clk) pin_in[3] = VEC[v][3];
      edges(4);
      wr(12'h800, 32'h8);
      wr(12'h00C, 32'(md) << 1);
      edges(3);
      rdreg(12'h800, rd);
      check($sformatf("R3-R8 row %0d armed mode %0d", v, md), rd, VEC[v][1] ? 32'h8 : 32'h0);
      wr(12'h800, 32'h8);
      @(negedge clk) pin_in[3] = VEC[v][2];
      edges(3);
      rdreg(12'h800, rd);
      check($sformatf("R13 R5 R6 R7 row %0d changed mode %0d", v, md), rd, VEC[v][0] ? 32'h8 : 32'h0);
      check($sformatf("R11 row %0d irq", v), 32'(irq[0]), 32'(VEC[v][0]));
    end
    wr(12'h00C, 32'hE);
    wr(12'h800, 32'hFFFF_FFFF);

    // R1 stored bits and mask
    wr(12'h014, 32'hFFFF_FFFF);
    rdreg(12'h014, rd); check("R1 mask readback", rd, 32'h00E7_8FEE);
    check("R2 oe with peripheral function", 32'(pin_oe[5]), 32'h0);

    // R2 live level versus stored data
    wr(12'h018, 32'hE);
    @(negedge clk) pin_in[6] = 1'b1;
    edges(3);
    rdreg(12'h018, rd); check("R2 live level", rd, 32'hF);
    @(negedge clk) pin_in[6] = 1'b0;
    wr(12'h018, 32'h3);
    edges(3);
    rdreg(12'h018, rd); check("R2 stored data", rd, 32'h3);
    check("R2 oe drive", 32'({pin_oe[6], pin_do[6]}), 32'h3);
    wr(12'h018, 32'h2);
    check("R2 do low", 32'({pin_oe[6], pin_do[6]}), 32'h2);

    // R9 routing: pin 35 to group 2, pin 36 to group 7 (out of range)
    wr(12'h08C, 32'h0002_0004);
    wr(12'h090, 32'h0007_0004);
    @(negedge clk) pin_in[36:35] = 2'b11;
    edges(4);
    rdreg(12'h884, rd); check("R9 group 2 word 1", rd, 32'h8);
    rdreg(12'h804, rd); check("R9 group 0 word 1", rd, 32'h0);
    check("R9 R11 irq lines", 32'(irq), 32'h4);

    // R10 zero write keeps, R3 clear while level present
    wr(12'h884, 32'h0);
    rdreg(12'h884, rd); check("R10 zero write", rd, 32'h8);
    wr(12'h884, 32'h8);
    rdreg(12'h884, rd); check("R3 clear under level", rd, 32'h8);
    @(negedge clk) pin_in[35] = 1'b0;
    edges(4);
    wr(12'h884, 32'h8);
    rdreg(12'h884, rd); check("R10 clear", rd, 32'h0);
    check("R11 irq drop", 32'(irq), 32'h0);

    // R8 mask and unmask with level present
    wr(12'h08C, 32'h0002_000E);
    @(negedge clk) pin_in[35] = 1'b1;
    edges(4);
    rdreg(12'h884, rd); check("R8 masked", rd, 32'h0);
    wr(12'h08C, 32'h0002_0004);
    edges(2);
    rdreg(12'h884, rd); check("R8 unmasked", rd, 32'h8);

    // R12 unmapped
    wr(12'h0A0, 32'hFFFF_FFFF);
    rdreg(12'h0A0, rd); check("R12 past last pin", rd, 32'h0);
    rdreg(12'h000, rd); check("R12 pin 0 untouched", rd, 32'h0);
    rdreg(12'h900, rd); check("R12 group out of range", rd, 32'h0);
    rdreg(12'h888, rd); check("R12 word out of range", rd, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule